// File: doc/BRIEF.md
# Trace Frame Packer

The block gathers cycles from a narrow trace port and packs them into 32-bit storage words. Every accepted input cycle carries a 3-bit pipeline status, a packet field, a sync flag and a trigger flag. The port width is selected by a mode input. In the 4-bit mode a word holds three slots, in the 8-bit mode two slots, and in the 16-bit mode one slot. When the last slot of a word is filled, the finished word is presented for one clock with a valid strobe. A flush input forces out a partly filled word.

A trigger cycle is marked inside the slot itself. The status field takes a reserved code, and the real status moves into the three low packet bits. A storage-side consumer that sees the reserved code can therefore recover both facts from one slot. When demultiplexed operation is requested, only the 8-bit width is legal. The unused mode code and any other pairing with demultiplexing are refused, and while refused the block ignores its inputs.

Top module: `trace_word_packer`

## Requirements
- R1: Mode code 2'b00 (4-bit port) places three 8-bit slots at word bits [7:0], [15:8] and [23:16], filled in arrival order. Each slot holds status in [2:0], packet[3:0] in [6:3] and sync in [7]. Word bits [31:24] are zero.
- R2: Mode code 2'b01 (8-bit port) places two 12-bit slots at word bits [11:0] and [23:12]. Each slot holds status in [2:0], packet[7:0] in [10:3] and sync in [11]. Word bits [31:24] are zero.
- R3: Mode code 2'b10 (16-bit port) puts one 20-bit slot in word bits [19:0]: status in [2:0], packet[15:0] in [18:3] and sync in [19]. Bits [31:20] are zero, and every accepted cycle completes a word.
- R4: On an accepted cycle with the trigger flag set, the slot's status field holds TRIG_CODE (default 3'b110). The slot's three low packet bits hold the real status, and the higher packet bits are kept.
- R5: A completed word appears on `word_out` with `word_valid` high for exactly one clock, in the cycle after the input that completed it. `word_valid` is low in every other cycle.
- R6: `cfg_reject` is high, combinationally, when the mode code is 2'b11, or when `demux` is high and the mode code is not 2'b01. While it is high, `in_valid` and `flush` have no effect, and the slots already filled are kept.
- R7: A flush emits the current partly filled word, including an input accepted in the same cycle, with unfilled slots zero. Filling then restarts at slot 0. A flush with no filled slot emits nothing.
- R8: When the mode code differs from its value in the previous cycle, filled slots are discarded and the input of that cycle, if any, goes to slot 0.
- R9: During and right after reset, `word_valid` is low and filling starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Port width: 00 = 4-bit, 01 = 8-bit, 10 = 16-bit, 11 = illegal |
| demux | input | 1 | Demultiplexed port operation requested |
| in_valid | input | 1 | Trace cycle present |
| in_status | input | 3 | Pipeline status of the cycle |
| in_packet | input | 16 | Packet field; only the low 4/8/16 bits are used per mode |
| in_sync | input | 1 | Sync flag of the cycle |
| in_trigger | input | 1 | Trigger flag of the cycle |
| flush | input | 1 | Emit the partly filled word |
| cfg_reject | output | 1 | Mode/demux pairing refused |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_out | output | 32 | Packed word |

## Verification
The bench aims at the slot boundary cases. A flush with an input in the same cycle must carry that input; a wrong design would drop it or emit it as a separate word. A flush with nothing filled must emit nothing; a wrong design would send an all-zero word. A mode change in mid-word must discard the old slots; a wrong design would mix slots of two widths in one word. A refused pairing must keep the slots already filled; a wrong design would either accept the refused inputs or lose the earlier slot. Trigger cycles are checked in every width, to catch a substituted status code that is misplaced, or real status bits that land in the wrong packet bits.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned PKT_W  = 16;
  localparam int unsigned STAT_W = 3;

  typedef enum logic [1:0] {
    MODE_N4  = 2'b00,
    MODE_N8  = 2'b01,
    MODE_N16 = 2'b10,
    MODE_BAD = 2'b11
  } port_mode_e;

  // packet bits carried per slot
  function automatic int unsigned pkt_bits(input logic [1:0] m);
    case (m)
      MODE_N4: return 4;
      MODE_N8: return 8;
      default: return 16;
    endcase
  endfunction

  // status + packet + sync
  function automatic int unsigned slot_bits(input logic [1:0] m);
    return pkt_bits(m) + STAT_W + 1;
  endfunction

  function automatic logic [1:0] slots_per_word(input logic [1:0] m);
    case (m)
      MODE_N4: return 2'd3;
      MODE_N8: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] encode_slot(
    input logic [1:0]        m,
    input logic [STAT_W-1:0] st,
    input logic [PKT_W-1:0]  pk,
    input logic              sy,
    input logic              tr,
    input logic [STAT_W-1:0] trig_code
  );
    logic [PKT_W:0]      msk;
    logic [PKT_W-1:0]    p;
    logic [WORD_W-1:0]   r;
    int unsigned         pb;
    pb  = pkt_bits(m);
    msk = (17'd1 << pb) - 17'd1;
    p   = pk & msk[PKT_W-1:0];
    if (tr) p[STAT_W-1:0] = st;
    r = '0;
    r[STAT_W-1:0] = tr ? trig_code : st;
    r = r | (WORD_W'(p) << STAT_W) | (WORD_W'(sy) << (STAT_W + pb));
    return r;
  endfunction

endpackage

// File: rtl/tfp_mode_guard.sv
module tfp_mode_guard
  import tfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       demux,
  output logic       reject,
  output logic       mode_chg
);
  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_N4;
    else        mode_q <= mode;
  end

  assign reject   = (mode == MODE_BAD) || (demux && (mode != MODE_N8));
  assign mode_chg = (mode != mode_q);
endmodule

// File: rtl/tfp_slot_encoder.sv
module tfp_slot_encoder
  import tfp_pkg::*;
#(
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  logic [1:0]        mode,
  input  logic [STAT_W-1:0] status,
  input  logic [PKT_W-1:0]  packet,
  input  logic              sync,
  input  logic              trigger,
  output logic [WORD_W-1:0] slot
);
  assign slot = encode_slot(mode, status, packet, sync, trigger, TRIG_CODE);
endmodule

// File: rtl/tfp_word_builder.sv
module tfp_word_builder
  import tfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              mode_chg,
  input  logic              take,
  input  logic              flush_ok,
  input  logic [WORD_W-1:0] slot,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [1:0]        slot_idx,
  output logic              emit
);
  logic [WORD_W-1:0] acc_q;
  logic [1:0]        idx_q;
  logic [1:0]        base_idx;
  logic [WORD_W-1:0] base_acc;
  logic [WORD_W-1:0] placed;
  logic              last_slot;
  logic              any_filled;

  always_comb begin
    base_idx   = mode_chg ? 2'd0 : idx_q;
    base_acc   = mode_chg ? '0 : acc_q;
    placed     = base_acc |
                 (take ? (slot << (32'(base_idx) * slot_bits(mode))) : '0);
    last_slot  = take && (base_idx == slots_per_word(mode) - 2'd1);
    any_filled = take || (base_idx != 2'd0);
    emit       = last_slot || (flush_ok && any_filled);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      idx_q     <= 2'd0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_word <= placed;
        acc_q    <= '0;
        idx_q    <= 2'd0;
      end else if (take) begin
        acc_q    <= placed;
        idx_q    <= base_idx + 2'd1;
      end else if (mode_chg) begin
        acc_q    <= '0;
        idx_q    <= 2'd0;
      end
    end
  end

  assign slot_idx = idx_q;
endmodule

// File: rtl/trace_word_packer.sv
module trace_word_packer
  import tfp_pkg::*;
#(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        demux,
  input  logic        in_valid,
  input  logic [2:0]  in_status,
  input  logic [15:0] in_packet,
  input  logic        in_sync,
  input  logic        in_trigger,
  input  logic        flush,
  output logic        cfg_reject,
  output logic        word_valid,
  output logic [31:0] word_out
);
  logic              mode_chg;
  logic              take;
  logic              flush_ok;
  logic              emit;
  logic [1:0]        slot_idx;
  logic [WORD_W-1:0] slot;

  tfp_mode_guard guard_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .demux    (demux),
    .reject   (cfg_reject),
    .mode_chg (mode_chg)
  );

  tfp_slot_encoder #(.TRIG_CODE(TRIG_CODE)) enc_i (
    .mode    (mode),
    .status  (in_status),
    .packet  (in_packet),
    .sync    (in_sync),
    .trigger (in_trigger),
    .slot    (slot)
  );

  assign take     = in_valid && !cfg_reject;
  assign flush_ok = flush && !cfg_reject;

  tfp_word_builder build_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .take      (take),
    .flush_ok  (flush_ok),
    .slot      (slot),
    .out_valid (word_valid),
    .out_word  (word_out),
    .slot_idx  (slot_idx),
    .emit      (emit)
  );
endmodule

// File: rtl/trace_word_packer_chk.sv
module trace_word_packer_chk #(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        in_valid,
  input logic [2:0]  in_status,
  input logic        in_trigger,
  input logic        flush,
  input logic        cfg_reject,
  input logic        word_valid,
  input logic [31:0] word_out,
  input logic [1:0]  slot_idx,
  input logic        mode_chg
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && ($past(mode) == 2'b00) |-> (word_out[31:24] == 8'd0));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && ($past(mode) == 2'b01) |-> (word_out[31:24] == 8'd0));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && ($past(mode) == 2'b10) |-> (word_out[31:20] == 12'd0));

  p_single_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mode == 2'b10) && !cfg_reject |=> word_valid);

  p_trig_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_trigger && (mode == 2'b10) && !cfg_reject |=>
      (word_out[2:0] == TRIG_CODE) && (word_out[5:3] == $past(in_status)));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !flush |=> !word_valid);

  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |=> !word_valid);

  p_flush_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !cfg_reject |=> (slot_idx == 2'd0));

  p_mode_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg && in_valid && !flush && !cfg_reject && (mode != 2'b10) |=>
      (slot_idx == 2'd1));
endmodule

bind trace_word_packer trace_word_packer_chk #(.TRIG_CODE(TRIG_CODE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .in_valid   (in_valid),
  .in_status  (in_status),
  .in_trigger (in_trigger),
  .flush      (flush),
  .cfg_reject (cfg_reject),
  .word_valid (word_valid),
  .word_out   (word_out),
  .slot_idx   (slot_idx),
  .mode_chg   (mode_chg)
);

// File: tb/trace_word_packer_tb_top.sv
module trace_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        demux = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_status = 3'd0;
  logic [15:0] in_packet = 16'd0;
  logic        in_sync = 1'b0;
  logic        in_trigger = 1'b0;
  logic        flush = 1'b0;
  logic        cfg_reject;
  logic        word_valid;
  logic [31:0] word_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_demux = 1'b0;
  logic [1:0]  m_mode = 2'b00;
  logic [31:0] m_acc = 32'd0;
  int          m_cnt = 0;

  always #2.5 clk = ~clk;

  trace_word_packer dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .demux(demux),
    .in_valid(in_valid), .in_status(in_status), .in_packet(in_packet),
    .in_sync(in_sync), .in_trigger(in_trigger), .flush(flush),
    .cfg_reject(cfg_reject), .word_valid(word_valid), .word_out(word_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench view of one slot, built by concatenation per width
  function automatic logic [31:0] ref_slot(input logic [1:0] m, input logic [2:0] st,
      input logic [15:0] pk, input logic sy, input logic tr);
    logic [2:0] s;
    s = tr ? 3'b110 : st;
    case (m)
      2'b00:   return {24'd0, sy, (tr ? {pk[3], st} : pk[3:0]), s};
      2'b01:   return {20'd0, sy, (tr ? {pk[7:3], st} : pk[7:0]), s};
      default: return {12'd0, sy, (tr ? {pk[15:3], st} : pk), s};
    endcase
  endfunction

  function automatic int ref_width(input logic [1:0] m);
    return (m == 2'b00) ? 8 : (m == 2'b01) ? 12 : 20;
  endfunction

  function automatic int ref_slots(input logic [1:0] m);
    return (m == 2'b00) ? 3 : (m == 2'b01) ? 2 : 1;
  endfunction

  // one input cycle: drive pins at negedge, update the expectation model
  task automatic step(input logic v, input logic [2:0] st, input logic [15:0] pk,
                      input logic sy, input logic tr, input logic fl, input string tag);
    bit rej;
    @(negedge clk);
    mode = cfg_mode; demux = cfg_demux;
    in_valid = v; in_status = st; in_packet = pk; in_sync = sy;
    in_trigger = tr; flush = fl;
    rej = (cfg_mode == 2'b11) || (cfg_demux && cfg_mode != 2'b01);
    if (cfg_mode != m_mode) begin m_acc = 32'd0; m_cnt = 0; end
    m_mode = cfg_mode;
    if (!rej) begin
      if (v) begin
        m_acc = m_acc | (ref_slot(cfg_mode, st, pk, sy, tr) << (m_cnt * ref_width(cfg_mode)));
        m_cnt++;
      end
      if (m_cnt == ref_slots(cfg_mode) || (fl && m_cnt != 0)) begin
        exp_q.push_back(m_acc);
        tag_q.push_back(tag);
        m_acc = 32'd0; m_cnt = 0;
      end
    end
    #1;
    check(cfg_reject == rej, "R6 cfg_reject", {31'd0, cfg_reject}, {31'd0, rej});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 1'b0, "R5 idle");
  endtask

  // monitor: every strobe must match the oldest expected word
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected word", word_out, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(word_out == e, t, word_out, e);
      end
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(word_valid == 1'b0, "R9 valid low in reset", {31'd0, word_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_valid == 1'b0, "R9 valid low after reset", {31'd0, word_valid}, 32'd0);

    // R1: 4-bit slots, two back-to-back words, sync bits spread
    cfg_mode = 2'b00;
    step(1, 3'd1, 16'h000A, 1, 0, 0, "R1 4-bit word a");
    step(1, 3'd2, 16'hFFF5, 0, 0, 0, "R1 4-bit word a");
    step(1, 3'd7, 16'h0003, 1, 0, 0, "R1 4-bit word a");
    step(1, 3'd4, 16'h000F, 0, 0, 0, "R1 4-bit word b");
    step(1, 3'd5, 16'h0001, 1, 0, 0, "R1 4-bit word b");
    step(1, 3'd0, 16'h0008, 1, 0, 0, "R1 4-bit word b");
    idle(2);

    // R4: trigger in 4-bit mode
    step(1, 3'd3, 16'h0009, 0, 1, 0, "R4 trigger 4-bit");
    step(1, 3'd5, 16'h0006, 1, 1, 0, "R4 trigger 4-bit");
    step(1, 3'd1, 16'h0002, 0, 0, 0, "R4 trigger 4-bit");
    idle(2);

    // R7: flush cases
    step(1, 3'd2, 16'h0005, 1, 0, 0, "R7 flush one slot");
    step(0, 3'd0, 16'h0000, 0, 0, 1, "R7 flush one slot");
    step(1, 3'd6, 16'h000C, 0, 0, 0, "R7 flush with input");
    step(1, 3'd1, 16'h0003, 1, 0, 1, "R7 flush with input");
    step(0, 3'd0, 16'h0000, 0, 0, 1, "R7 empty flush");
    idle(2);

    // R2: 8-bit mode with demux (accepted)
    cfg_mode = 2'b01; cfg_demux = 1'b1;
    step(1, 3'd3, 16'h00A5, 1, 0, 0, "R2 8-bit word");
    step(1, 3'd6, 16'h005A, 1, 0, 0, "R2 8-bit word");
    step(1, 3'd2, 16'h00F0, 0, 1, 0, "R4 trigger 8-bit");
    step(1, 3'd7, 16'h0033, 1, 1, 0, "R4 trigger 8-bit");
    cfg_demux = 1'b0;
    idle(2);

    // R3: 16-bit mode, every input a word
    cfg_mode = 2'b10;
    step(1, 3'd5, 16'hBEEF, 1, 0, 0, "R3 16-bit word");
    step(1, 3'd0, 16'h1234, 0, 0, 0, "R3 16-bit word");
    step(1, 3'd4, 16'hFFFF, 1, 1, 0, "R4 trigger 16-bit");
    idle(2);

    // R8: mode change discards a partial word
    cfg_mode = 2'b00;
    step(1, 3'd1, 16'h0001, 0, 0, 0, "R8 discarded");
    step(1, 3'd2, 16'h0002, 0, 0, 0, "R8 discarded");
    cfg_mode = 2'b01;
    step(1, 3'd3, 16'h0077, 0, 0, 0, "R8 new mode word");
    step(1, 3'd4, 16'h0088, 1, 0, 0, "R8 new mode word");
    idle(2);

    // R6: refused pairing ignores inputs and flush, keeps filled slots
    cfg_mode = 2'b00;
    step(1, 3'd7, 16'h0004, 1, 0, 0, "R6 kept slot");
    cfg_demux = 1'b1;
    step(1, 3'd1, 16'h000F, 1, 0, 0, "R6 ignored");
    step(0, 3'd0, 16'h0000, 0, 0, 1, "R6 ignored flush");
    cfg_demux = 1'b0;
    step(1, 3'd2, 16'h0009, 0, 0, 0, "R6 kept slot");
    step(1, 3'd3, 16'h0006, 1, 0, 0, "R6 kept slot");
    idle(2);

    // R6: illegal mode code
    cfg_mode = 2'b11;
    step(1, 3'd5, 16'h0005, 1, 0, 1, "R6 illegal mode");
    idle(3);

    check(exp_q.size() == 0, "R5 missing words", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule